// File: doc/BRIEF.md
# Reflectometry Test Sequencer

This block steps a single cable-reflectometry measurement through its timed phases. A start command opens a quiet interval before any stimulus, then raises a transmit enable for the modulated probe signal for a programmed number of microseconds. A second quiet interval follows. The line is then handed back to normal forced-link operation. All phase timing is counted on a one-cycle microsecond tick supplied from outside. Millisecond silence intervals are derived from that tick through the `US_PER_MS` parameter.

Software programs the sequencer through a small register port and reads it back the same way. Through that port it sets the two silence codes, the transmit amplitude, the transmit duration and the correlator tap window. It also starts a test and reads back completion, failure and the fault report. An external correlator presents a peak-detect strobe with sign and location while the trailing silence runs. The sequencer captures that result in a fault status word, where the sign tells an open from a short. If the line shows activity before the trailing silence, the run is abandoned and flagged as failed.

Top module: `refl_test_seq`

## Requirements
- R1: After reset txEnable and forcedLink are 0, every status bit and the fault word read 0, the configuration word (address 1) reads 0, the duration (address 2) reads 16000, tapStartIdx is 4 and tapEndIdx is 36.
- R2: A write to address 0 with bit 15 set starts a test. A write to address 0 with bit 15 clear starts nothing. Bit 15 of address 0 reads 1 while a test is in progress.
- R3: A test runs its phases strictly in the order leading silence, transmit window, trailing silence, forced link. forcedLink stays 1 until the next start.
- R4: The leading silence code is address 1 bits [1:0] and the trailing code is bits [3:2]. Codes 0, 1, 2 and 3 select 0, 10, 100 and 1000 ms, where one ms is US_PER_MS ticks. A phase of N ticks lasts N cycles when usTick is always high. A zero-length phase takes one cycle.
- R5: txEnable stays high for the 16-bit tick count held at address 2, and for one cycle when that count is 0.
- R6: txAmpHigh follows address 1 bit 12: 0 selects the 1 V level and 1 selects the 2.4 V level.
- R7: Done (address 0 bit 1) becomes 1 in the first cycle of the trailing silence. A run without line activity leaves fail (bit 0) at 0.
- R8: If lineActive is high during the leading silence or the transmit window, the next cycle has txEnable 0, forcedLink 1, done 1 and fail 1.
- R9: A peakValid strobe during the trailing silence sets the fault word (address 4) to bit 11 = 1, bit 10 = peak sign and bits [9:0] = location. Sign 1 reports an open and sign 0 reports a short. With no strobe the word stays 0, which reports the cable as good.
- R10: A peakValid strobe outside the trailing silence leaves the fault word unchanged.
- R11: A new start clears done, fail and the fault word in the cycle that follows it.
- R12: Address 3 holds the end tap index in bits [14:8] and the start tap index in bits [6:0]. These fields drive tapEndIdx and tapStartIdx.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-cycle pulse per microsecond |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for addr (combinational) |
| lineActive | input | 1 | Line activity seen by the receiver |
| peakValid | input | 1 | Correlator peak-detect strobe |
| peakSign | input | 1 | Peak polarity, 1 = open, 0 = short |
| peakLoc | input | 10 | Peak location |
| txEnable | output | 1 | Modulated transmit enable |
| txAmpHigh | output | 1 | Transmit amplitude select |
| forcedLink | output | 1 | Line returned to forced-link operation |
| tapStartIdx | output | 7 | Correlator window start tap |
| tapEndIdx | output | 7 | Correlator window end tap |

## Verification
On every cycle the assertions check that the phases are entered in order, that line activity forces release in the next cycle, that fail never stands without done, that a start clears the status, and that the fault word only moves inside the peak window. The exact phase lengths for each silence code and duration can only be shown by the bench scenarios. The same holds for the latched sign and location, the ignoring of early peaks, and the abort in each phase. The bench sweeps every pair of leading and trailing codes and measures each phase length at the ports.

// File: rtl/refl_seq_pkg.sv
package refl_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_TX,
    PH_POST,
    PH_FORCED
  } phase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic markDone;
    logic markFail;
    logic peakWin;
  } seqStrobe_t;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_CFG   = 3'd1;
  localparam logic [2:0] ADDR_DUR   = 3'd2;
  localparam logic [2:0] ADDR_TAPS  = 3'd3;
  localparam logic [2:0] ADDR_FAULT = 3'd4;

  localparam int START_BIT = 15;
  localparam int AMP_BIT   = 12;

endpackage

// File: rtl/refl_seq_ctrl.sv
module refl_seq_ctrl
  import refl_seq_pkg::*;
#(
  parameter int US_PER_MS = 1000,
  parameter int DUR_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             startReq,
  input  logic             lineActive,
  input  logic [1:0]       preCode,
  input  logic [1:0]       postCode,
  input  logic [DUR_W-1:0] txDur,
  output seqStrobe_t       strobe,
  output logic             txEnable,
  output logic             forcedLink,
  output logic             busy
);

  localparam int MAX_SIL   = 1000 * US_PER_MS;
  localparam int MAX_DUR   = (1 << DUR_W) - 1;
  localparam int MAX_TICKS = (MAX_SIL > MAX_DUR) ? MAX_SIL : MAX_DUR;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  phase_e           phase;
  logic [CNT_W-1:0] remain;
  logic             expire;
  logic             abortNow;

  function automatic logic [CNT_W-1:0] silTicks(input logic [1:0] code);
    case (code)
      2'd0:    silTicks = '0;
      2'd1:    silTicks = CNT_W'(10 * US_PER_MS);
      2'd2:    silTicks = CNT_W'(100 * US_PER_MS);
      default: silTicks = CNT_W'(1000 * US_PER_MS);
    endcase
  endfunction

  assign expire   = (remain == '0) || (usTick && (remain == CNT_W'(1)));
  assign abortNow = !startReq && lineActive &&
                    ((phase == PH_PRE) || (phase == PH_TX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      remain <= '0;
    end else if (startReq) begin
      phase  <= PH_PRE;
      remain <= silTicks(preCode);
    end else begin
      case (phase)
        PH_PRE: begin
          if (lineActive) begin
            phase <= PH_FORCED;
          end else if (expire) begin
            phase  <= PH_TX;
            remain <= CNT_W'(txDur);
          end else if (usTick) begin
            remain <= remain - CNT_W'(1);
          end
        end
        PH_TX: begin
          if (lineActive) begin
            phase <= PH_FORCED;
          end else if (expire) begin
            phase  <= PH_POST;
            remain <= silTicks(postCode);
          end else if (usTick) begin
            remain <= remain - CNT_W'(1);
          end
        end
        PH_POST: begin
          if (expire) begin
            phase <= PH_FORCED;
          end else if (usTick) begin
            remain <= remain - CNT_W'(1);
          end
        end
        default: begin
          phase <= phase;
        end
      endcase
    end
  end

  always_comb begin
    strobe.markFail = abortNow;
    strobe.markDone = abortNow ||
                      (!startReq && (phase == PH_TX) && !lineActive && expire);
    strobe.peakWin  = (phase == PH_POST);
  end

  assign txEnable   = (phase == PH_TX);
  assign forcedLink = (phase == PH_FORCED);
  assign busy       = (phase == PH_PRE) || (phase == PH_TX) || (phase == PH_POST);

  // R8: activity in a live phase releases the line on the next cycle
  a_r8_abort_release: assert property (@(posedge clk) disable iff (!rstN)
    abortNow |=> (forcedLink && !txEnable));

  // R3: transmit only opens straight out of the leading silence
  a_r3_tx_after_pre: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |-> ($past(phase) == PH_PRE));

  // R3: trailing silence only follows the transmit window
  a_r3_post_after_tx: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_POST) && ($past(phase) != PH_POST)) |-> ($past(phase) == PH_TX));

  // R2: a start always lands in the leading silence
  a_r2_start_enters_pre: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (phase == PH_PRE));

endmodule

// File: rtl/refl_seq_dp.sv
module refl_seq_dp
  import refl_seq_pkg::*;
#(
  parameter int DUR_W       = 16,
  parameter int TAP_W       = 7,
  parameter int LOC_W       = 10,
  parameter int DUR_DEFAULT = 16000,
  parameter int TAP_START_D = 4,
  parameter int TAP_END_D   = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [15:0]      wrData,
  output logic [15:0]      rdData,
  input  logic             peakValid,
  input  logic             peakSign,
  input  logic [LOC_W-1:0] peakLoc,
  input  seqStrobe_t       strobe,
  input  logic             busy,
  output logic             startReq,
  output logic [1:0]       preCode,
  output logic [1:0]       postCode,
  output logic [DUR_W-1:0] txDur,
  output logic             txAmpHigh,
  output logic [TAP_W-1:0] tapStartIdx,
  output logic [TAP_W-1:0] tapEndIdx
);

  localparam int FAULT_W = LOC_W + 2;

  logic               doneFlag;
  logic               failFlag;
  logic [FAULT_W-1:0] faultWord;

  assign startReq = wrEn && (addr == ADDR_CTRL) && wrData[START_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCode     <= '0;
      postCode    <= '0;
      txAmpHigh   <= 1'b0;
      txDur       <= DUR_W'(DUR_DEFAULT);
      tapStartIdx <= TAP_W'(TAP_START_D);
      tapEndIdx   <= TAP_W'(TAP_END_D);
    end else if (wrEn) begin
      case (addr)
        ADDR_CFG: begin
          preCode   <= wrData[1:0];
          postCode  <= wrData[3:2];
          txAmpHigh <= wrData[AMP_BIT];
        end
        ADDR_DUR:  txDur <= wrData[DUR_W-1:0];
        ADDR_TAPS: begin
          tapStartIdx <= wrData[TAP_W-1:0];
          tapEndIdx   <= wrData[8 +: TAP_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag  <= 1'b0;
      failFlag  <= 1'b0;
      faultWord <= '0;
    end else if (startReq) begin
      doneFlag  <= 1'b0;
      failFlag  <= 1'b0;
      faultWord <= '0;
    end else begin
      if (strobe.markDone) doneFlag <= 1'b1;
      if (strobe.markFail) failFlag <= 1'b1;
      if (strobe.peakWin && peakValid) faultWord <= {1'b1, peakSign, peakLoc};
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL:  rdData = {busy, 13'b0, doneFlag, failFlag};
      ADDR_CFG:   rdData = {3'b0, txAmpHigh, 8'b0, postCode, preCode};
      ADDR_DUR:   rdData = 16'(txDur);
      ADDR_TAPS:  rdData = {1'b0, tapEndIdx, 1'b0, tapStartIdx};
      ADDR_FAULT: rdData = 16'(faultWord);
      default:    rdData = '0;
    endcase
  end

  // R7: a failed run is always also a finished run
  a_r7_fail_implies_done: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |-> doneFlag);

  // R11: a start wipes the previous result
  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (!doneFlag && !failFlag && (faultWord == '0)));

  // R10: the fault word only moves inside the peak window or on a start
  a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.peakWin && !startReq) |=> $stable(faultWord));

endmodule

// File: rtl/refl_test_seq.sv
module refl_test_seq
  import refl_seq_pkg::*;
#(
  parameter int US_PER_MS = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        usTick,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        lineActive,
  input  logic        peakValid,
  input  logic        peakSign,
  input  logic [9:0]  peakLoc,
  output logic        txEnable,
  output logic        txAmpHigh,
  output logic        forcedLink,
  output logic [6:0]  tapStartIdx,
  output logic [6:0]  tapEndIdx
);

  localparam int DUR_W = 16;
  localparam int TAP_W = 7;
  localparam int LOC_W = 10;

  seqStrobe_t       strobe;
  logic             startReq;
  logic             busy;
  logic [1:0]       preCode;
  logic [1:0]       postCode;
  logic [DUR_W-1:0] txDur;

  refl_seq_ctrl #(
    .US_PER_MS (US_PER_MS),
    .DUR_W     (DUR_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .usTick     (usTick),
    .startReq   (startReq),
    .lineActive (lineActive),
    .preCode    (preCode),
    .postCode   (postCode),
    .txDur      (txDur),
    .strobe     (strobe),
    .txEnable   (txEnable),
    .forcedLink (forcedLink),
    .busy       (busy)
  );

  refl_seq_dp #(
    .DUR_W (DUR_W),
    .TAP_W (TAP_W),
    .LOC_W (LOC_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .addr        (addr),
    .wrData      (wrData),
    .rdData      (rdData),
    .peakValid   (peakValid),
    .peakSign    (peakSign),
    .peakLoc     (peakLoc),
    .strobe      (strobe),
    .busy        (busy),
    .startReq    (startReq),
    .preCode     (preCode),
    .postCode    (postCode),
    .txDur       (txDur),
    .txAmpHigh   (txAmpHigh),
    .tapStartIdx (tapStartIdx),
    .tapEndIdx   (tapEndIdx)
  );

endmodule

// File: tb/test_refl_test_seq.sv
module test_refl_test_seq;

  localparam int CLK_PERIOD = 10;
  localparam int US_PER_MS  = 2;
  localparam int LIMIT      = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        lineActive = 1'b0;
  logic        peakValid = 1'b0;
  logic        peakSign = 1'b0;
  logic [9:0]  peakLoc = '0;
  logic        txEnable;
  logic        txAmpHigh;
  logic        forcedLink;
  logic [6:0]  tapStartIdx;
  logic [6:0]  tapEndIdx;

  int vectors = 0;
  int misses  = 0;

  refl_test_seq #(.US_PER_MS(US_PER_MS)) i_refl_test_seq (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .lineActive(lineActive),
    .peakValid(peakValid), .peakSign(peakSign), .peakLoc(peakLoc),
    .txEnable(txEnable), .txAmpHigh(txAmpHigh), .forcedLink(forcedLink),
    .tapStartIdx(tapStartIdx), .tapEndIdx(tapEndIdx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    misses++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdData);
  endtask

  function automatic int silMs(input int code);
    case (code)
      0: return 0;
      1: return 10;
      2: return 100;
      default: return 1000;
    endcase
  endfunction

  function automatic int atLeastOne(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  // one complete run; dur < 0 keeps the stored duration
  task automatic runTest(input int pre, input int post, input int dur,
                         input int expDur, input bit amp, input bit peak,
                         input bit sign, input int loc, input bit earlyPeak);
    int cnt;
    int v;
    regWrite(3'd1, 16'((int'(amp) << 12) | (post << 2) | pre));
    if (dur >= 0) regWrite(3'd2, 16'(dur));
    regWrite(3'd0, 16'h8000);
    regRead(3'd0, v);
    chk("R2 busy bit during run", (v >> 15) & 1, 1);
    peakValid = earlyPeak; peakSign = 1'b1; peakLoc = 10'h3FF;
    cnt = 0;
    while (!txEnable && !forcedLink && cnt < LIMIT) begin
      cnt++; @(negedge clk);
    end
    chk("R4 leading silence cycles", cnt, atLeastOne(silMs(pre) * US_PER_MS));
    chk("R6 amplitude select", int'(txAmpHigh), int'(amp));
    cnt = 0;
    while (txEnable && cnt < LIMIT) begin
      cnt++; @(negedge clk);
    end
    peakValid = 1'b0;
    chk("R5 transmit window cycles", cnt, atLeastOne(expDur));
    regRead(3'd0, v);
    chk("R7 done at trailing silence start", v & 3, 2);
    chk("R3 trailing silence follows transmit", int'(forcedLink), 0);
    if (peak) begin
      peakValid = 1'b1; peakSign = sign; peakLoc = 10'(loc);
    end
    cnt = 0;
    while (!forcedLink && cnt < LIMIT) begin
      cnt++; @(negedge clk);
      peakValid = 1'b0;
    end
    chk("R4 trailing silence cycles", cnt, atLeastOne(silMs(post) * US_PER_MS));
    regRead(3'd4, v);
    if (peak) chk("R9 fault word latched", v, (1 << 11) | (int'(sign) << 10) | loc);
    else if (earlyPeak) chk("R10 early peak ignored", v, 0);
    else chk("R9 no peak reports good cable", v, 0);
    regRead(3'd0, v);
    chk("R7 final status", v, 2);
    @(negedge clk);
    chk("R3 forced link held", int'(forcedLink), 1);
  endtask

  initial begin
    int v;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txEnable", int'(txEnable), 0);
    chk("R1 forcedLink", int'(forcedLink), 0);
    regRead(3'd0, v); chk("R1 status", v, 0);
    regRead(3'd1, v); chk("R1 config", v, 0);
    regRead(3'd2, v); chk("R1 duration default", v, 16000);
    regRead(3'd4, v); chk("R1 fault word", v, 0);
    chk("R1 start tap", int'(tapStartIdx), 4);
    chk("R1 end tap", int'(tapEndIdx), 36);

    // R2 a control write without bit 15 does nothing
    regWrite(3'd0, 16'h7FFF);
    repeat (3) @(negedge clk);
    chk("R2 no start txEnable", int'(txEnable), 0);
    regRead(3'd0, v); chk("R2 no start status", v, 0);

    // R5 default duration
    runTest(0, 0, -1, 16000, 1'b0, 1'b0, 1'b0, 0, 1'b0);

    // R12 tap fields
    regWrite(3'd3, 16'h2A05);
    chk("R12 end tap", int'(tapEndIdx), 42);
    chk("R12 start tap", int'(tapStartIdx), 5);
    regRead(3'd3, v); chk("R12 tap readback", v, 16'h2A05);

    // sweep all code pairs
    for (int pr = 0; pr < 4; pr++) begin
      for (int po = 0; po < 4; po++) begin
        int d;
        bit pk;
        d  = pr * 3 + po;
        pk = ((pr + po) % 3) != 0;
        runTest(pr, po, d, d, bit'((pr ^ po) & 1), pk, bit'(po & 1),
                pr * 100 + po * 7 + 1, !pk);
      end
    end

    // R11 restart clears the previous result
    runTest(1, 1, 5, 5, 1'b0, 1'b1, 1'b1, 321, 1'b0);
    regWrite(3'd0, 16'h8000);
    regRead(3'd0, v); chk("R11 status cleared", v & 3, 0);
    regRead(3'd4, v); chk("R11 fault cleared", v, 0);
    cnt = 0;
    while (!forcedLink && cnt < LIMIT) begin cnt++; @(negedge clk); end

    // R8 abort in leading silence
    regWrite(3'd1, 16'h0002);
    regWrite(3'd0, 16'h8000);
    repeat (5) @(negedge clk);
    lineActive = 1'b1;
    @(negedge clk);
    lineActive = 1'b0;
    chk("R8 pre abort forcedLink", int'(forcedLink), 1);
    chk("R8 pre abort txEnable", int'(txEnable), 0);
    regRead(3'd0, v); chk("R8 pre abort status", v, 3);

    // R8 abort in transmit window
    regWrite(3'd2, 16'd50);
    regWrite(3'd0, 16'h8000);
    regRead(3'd0, v); chk("R11 abort status cleared", v & 3, 0);
    cnt = 0;
    while (!txEnable && cnt < LIMIT) begin cnt++; @(negedge clk); end
    repeat (3) @(negedge clk);
    lineActive = 1'b1;
    @(negedge clk);
    lineActive = 1'b0;
    chk("R8 tx abort txEnable", int'(txEnable), 0);
    chk("R8 tx abort forcedLink", int'(forcedLink), 1);
    regRead(3'd0, v); chk("R8 tx abort status", v, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule